// File: doc/BRIEF.md
# Interval Timer Host Bus Front End

This block sits between a byte-wide host bus and three counter channels of an interval timer. Two address bits pick one of four ports. Ports 0, 1 and 2 belong to the three channels. Port 3 is the shared control port. Bus inputs are treated as synchronous to the block clock. A write takes effect on the rising edge of the write strobe, and only if chip select was low. The block turns each accepted write into one-cycle command pulses aimed at a single channel, or at several channels when the write is a read-back command.

Every control byte carries its own target channel, so the host can interleave programming steps for different channels in any order. For each channel the front end tracks whether a control word has arrived and which byte format it chose. Count bytes are therefore steered as low or high bytes, and the block signals when a full initial count has been delivered. Count bytes sent to a channel that has never been programmed are dropped.

Reads are combinational. The addressed channel's current byte is driven out while chip select and the read strobe are both low. The rising edge of the read strobe is reported to that channel so that it can step its own byte sequence.

Top module: `pit_host_front`

## Requirements
- R1: A write is accepted only on a rising edge of `wr_n`, and only when `cs_n` was low while the strobe was low. Any write strobe seen while `cs_n` is high produces no command pulse.
- R2: A write to port 3 with select bits [7:6] in 0..2 and format bits [5:4] not 00 pulses `ch_mode_we` for that channel only, for one cycle. In the same cycle `cfg_fmt`=bits[5:4], `cfg_mode`=bits[3:1] and `cfg_bcd`=bit[0].
- R3: A write to port 3 with select 0..2 and format bits 00 is a latch command. It pulses `ch_cnt_latch` for the selected channel and leaves that channel's mode and byte format unchanged.
- R4: A write to port 3 with select 11 is a read-back command, and bits[3:1] are a mask for channels 2, 1 and 0. When bit 5 is 0 it pulses `ch_cnt_latch` for every masked channel. When bit 4 is 0 it pulses `ch_sts_latch` for every masked channel. It pulses no `ch_mode_we`.
- R5: Until a channel has received a control word with a format other than 00, bytes written to its port produce no `ch_byte_we` and no `ch_count_ready`.
- R6: In format 01 every accepted byte is a low byte (`byte_is_msb`=0). In format 10 every accepted byte is a high byte (`byte_is_msb`=1). In both formats each byte also pulses `ch_count_ready`, and `byte_data` carries the byte.
- R7: In format 11 the first byte is low with no ready pulse, and the second byte is high with a ready pulse. Any new control word for the channel restarts the sequence at the low byte.
- R8: Each channel's programmed state, format and byte position change only through writes aimed at that channel, so programming steps for different channels may be interleaved.
- R9: While `cs_n` and `rd_n` are both low and `addr` is 0..2, `bus_rdata` equals that channel's byte from `ch_rdata` (channel i at bits [8i+7:8i]) and `bus_oe` is 1. In every other case `bus_rdata` is 0 and `bus_oe` is 0.
- R10: A rising edge of `rd_n` with `cs_n` low and `addr` 0..2 pulses `ch_rd_done` for that channel. A read at port 3 pulses nothing.
- R11: After reset all command pulses are low and no channel counts as programmed.
- R12: At most one channel receives `ch_mode_we`, and at most one receives `ch_byte_we`, in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Port select: 0..2 channels, 3 control |
| wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, 0 when not driving |
| bus_oe | output | 1 | Read data valid/drive enable |
| ch_rdata | input | 24 | Current read byte of each channel |
| ch_mode_we | output | 3 | Per-channel control word load pulse |
| cfg_fmt | output | 2 | Byte format of the last control word |
| cfg_mode | output | 3 | Mode field of the last control word |
| cfg_bcd | output | 1 | Decimal counting flag of the last control word |
| ch_cnt_latch | output | 3 | Per-channel count latch pulse |
| ch_sts_latch | output | 3 | Per-channel status latch pulse |
| ch_byte_we | output | 3 | Per-channel count byte write pulse |
| byte_data | output | 8 | Count byte being written |
| byte_is_msb | output | 1 | Count byte is the high byte |
| ch_count_ready | output | 3 | Per-channel full initial count delivered |
| ch_rd_done | output | 3 | Per-channel read strobe completed |

## Verification
The bench uses the package defaults: three channels on byte-wide data. With two address bits, that covers every port, including the control port, and every select code, including the read-back code. With these values every read-back mask combination lies within reach, and so does every format. The directed tests interleave control words and count bytes across channels. This exposes shared-state faults in the per-channel byte position.

// File: rtl/pit_host_pkg.sv
package pit_host_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int NCH     = 3;
  localparam int RD_W    = NCH * BYTE_W;
  localparam logic [ADDR_W-1:0] CTRL_PORT = ADDR_W'(NCH);
  localparam logic [1:0] SEL_RB   = 2'b11;
  localparam logic [1:0] FMT_CMD  = 2'b00;
  localparam logic [1:0] FMT_LO   = 2'b01;
  localparam logic [1:0] FMT_HI   = 2'b10;
  localparam logic [1:0] FMT_PAIR = 2'b11;

  // byte steering: is the next byte the high half of the count
  function automatic logic fmt_byte_hi(input logic [1:0] fmt, input logic second);
    return (fmt == FMT_HI) || ((fmt == FMT_PAIR) && second);
  endfunction

  // does the next byte complete the initial count
  function automatic logic fmt_byte_last(input logic [1:0] fmt, input logic second);
    return (fmt != FMT_PAIR) || second;
  endfunction
endpackage

// File: rtl/pit_bus_sync.sv
module pit_bus_sync
  import pit_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              wr_evt,
  output logic              rd_evt,
  output logic [ADDR_W-1:0] evt_addr,
  output logic [BYTE_W-1:0] evt_data
);
  logic              wr_s1, wr_s2, rd_s1, rd_s2, cs_s1, cs_s2;
  logic [ADDR_W-1:0] a_s1, a_s2;
  logic [BYTE_W-1:0] d_s1, d_s2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_s1 <= 1'b1; wr_s2 <= 1'b1;
      rd_s1 <= 1'b1; rd_s2 <= 1'b1;
      cs_s1 <= 1'b1; cs_s2 <= 1'b1;
      a_s1  <= '0;   a_s2  <= '0;
      d_s1  <= '0;   d_s2  <= '0;
    end else begin
      wr_s1 <= wr_n;  wr_s2 <= wr_s1;
      rd_s1 <= rd_n;  rd_s2 <= rd_s1;
      cs_s1 <= cs_n;  cs_s2 <= cs_s1;
      a_s1  <= addr;  a_s2  <= a_s1;
      d_s1  <= wdata; d_s2  <= d_s1;
    end
  end

  // strobe rose; select/address/data taken from the cycle the strobe was low
  assign wr_evt   = wr_s1 & ~wr_s2 & ~cs_s2;
  assign rd_evt   = rd_s1 & ~rd_s2 & ~cs_s2;
  assign evt_addr = a_s2;
  assign evt_data = d_s2;
endmodule

// File: rtl/pit_cw_decode.sv
module pit_cw_decode
  import pit_host_pkg::*;
(
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [BYTE_W-1:1] evt_hi,
  output logic [NCH-1:0]    mode_hit,
  output logic [NCH-1:0]    latch_hit,
  output logic [NCH-1:0]    sts_hit,
  output logic [NCH-1:0]    byte_hit
);
  logic       is_ctrl, is_rb;
  logic [1:0] sel, fmt;
  logic [NCH-1:0] mask;

  assign is_ctrl = wr_evt && (evt_addr == CTRL_PORT);
  assign sel     = evt_hi[7:6];
  assign fmt     = evt_hi[5:4];
  assign mask    = evt_hi[NCH:1];
  assign is_rb   = is_ctrl && (sel == SEL_RB);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic tgt;
    assign tgt          = is_ctrl && (sel == 2'(i));
    assign mode_hit[i]  = tgt && (fmt != FMT_CMD);
    assign latch_hit[i] = (tgt && (fmt == FMT_CMD)) || (is_rb && mask[i] && !evt_hi[5]);
    assign sts_hit[i]   = is_rb && mask[i] && !evt_hi[4];
    assign byte_hit[i]  = wr_evt && (evt_addr == ADDR_W'(i));
  end
endmodule

// File: rtl/pit_ch_track.sv
module pit_ch_track
  import pit_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_hit,
  input  logic [1:0] fmt_in,
  input  logic       byte_hit,
  output logic       accept,
  output logic       hi_byte,
  output logic       last_byte
);
  logic       armed, second;
  logic [1:0] fmt_q;

  assign accept    = byte_hit && armed;
  assign hi_byte   = fmt_byte_hi(fmt_q, second);
  assign last_byte = accept && fmt_byte_last(fmt_q, second);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      second <= 1'b0;
      fmt_q  <= FMT_CMD;
    end else if (mode_hit) begin
      armed  <= 1'b1;
      second <= 1'b0;
      fmt_q  <= fmt_in;
    end else if (accept && (fmt_q == FMT_PAIR)) begin
      second <= ~second;
    end
  end
endmodule

// File: rtl/pit_host_front.sv
module pit_host_front
  import pit_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_oe,
  input  logic [23:0]       ch_rdata,
  output logic [2:0]        ch_mode_we,
  output logic [1:0]        cfg_fmt,
  output logic [2:0]        cfg_mode,
  output logic              cfg_bcd,
  output logic [2:0]        ch_cnt_latch,
  output logic [2:0]        ch_sts_latch,
  output logic [2:0]        ch_byte_we,
  output logic [7:0]        byte_data,
  output logic              byte_is_msb,
  output logic [2:0]        ch_count_ready,
  output logic [2:0]        ch_rd_done
);
  logic              wr_evt, rd_evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [BYTE_W-1:0] evt_data;
  logic [NCH-1:0]    mode_hit, latch_hit, sts_hit, byte_hit;
  logic [NCH-1:0]    acc, hi_b, last_b, rd_hit;
  logic              any_hi, rd_live;

  pit_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .evt_addr(evt_addr), .evt_data(evt_data)
  );

  pit_cw_decode u_dec (
    .wr_evt(wr_evt), .evt_addr(evt_addr), .evt_hi(evt_data[BYTE_W-1:1]),
    .mode_hit(mode_hit), .latch_hit(latch_hit), .sts_hit(sts_hit),
    .byte_hit(byte_hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_trk
    pit_ch_track u_trk (
      .clk(clk), .rst_n(rst_n), .mode_hit(mode_hit[i]),
      .fmt_in(evt_data[5:4]), .byte_hit(byte_hit[i]),
      .accept(acc[i]), .hi_byte(hi_b[i]), .last_byte(last_b[i])
    );
    assign rd_hit[i] = rd_evt && (evt_addr == ADDR_W'(i));
  end

  assign any_hi = |(acc & hi_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_mode_we     <= '0;
      ch_cnt_latch   <= '0;
      ch_sts_latch   <= '0;
      ch_byte_we     <= '0;
      ch_count_ready <= '0;
      ch_rd_done     <= '0;
      cfg_fmt        <= FMT_CMD;
      cfg_mode       <= '0;
      cfg_bcd        <= 1'b0;
      byte_data      <= '0;
      byte_is_msb    <= 1'b0;
    end else begin
      ch_mode_we     <= mode_hit;
      ch_cnt_latch   <= latch_hit;
      ch_sts_latch   <= sts_hit;
      ch_byte_we     <= acc;
      ch_count_ready <= last_b;
      ch_rd_done     <= rd_hit;
      if (|mode_hit) begin
        cfg_fmt  <= evt_data[5:4];
        cfg_mode <= evt_data[3:1];
        cfg_bcd  <= evt_data[0];
      end
      if (|acc) begin
        byte_data   <= evt_data;
        byte_is_msb <= any_hi;
      end
    end
  end

  // combinational read path
  assign rd_live = !cs_n && !rd_n && (addr != CTRL_PORT);
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (rd_live && (addr == ADDR_W'(i))) bus_rdata = ch_rdata[i*BYTE_W +: BYTE_W];
  end
  assign bus_oe = rd_live;
endmodule

// File: rtl/pit_host_front_chk.sv
module pit_host_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wr_n,
  input logic [1:0] addr,
  input logic [2:0] ch_mode_we,
  input logic [2:0] ch_byte_we,
  input logic [2:0] ch_count_ready,
  input logic [2:0] ch_sts_latch
);
  AST_ONE_MODE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_mode_we)); // R12
  AST_ONE_BYTE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_byte_we)); // R12
  AST_MODE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mode_we != 3'b000) |=> (ch_mode_we == 3'b000)); // R2
  AST_READY_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_count_ready & ~ch_byte_we) == 3'b000); // R6
  AST_STS_NOT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_sts_latch != 3'b000) |-> (ch_mode_we == 3'b000)); // R4
  AST_BYTE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_byte_we != 3'b000) |-> (!$past(cs_n, 3) && $past(wr_n, 2) && !$past(wr_n, 3))); // R1
  AST_BYTE_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_byte_we != 3'b000) |-> (ch_byte_we == (3'b001 << $past(addr, 3)))); // R8
endmodule

bind pit_host_front pit_host_front_chk u_chk (.*);

// File: tb/sim_pit_host_front.sv
module sim_pit_host_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic bus_oe;
  logic [23:0] ch_rdata = {8'hC2, 8'hB1, 8'hA0};
  logic [2:0] ch_mode_we, ch_cnt_latch, ch_sts_latch, ch_byte_we, ch_count_ready, ch_rd_done;
  logic [1:0] cfg_fmt;
  logic [2:0] cfg_mode;
  logic cfg_bcd, byte_is_msb;
  logic [7:0] byte_data;

  int checks = 0, errors = 0;
  int n_mode[3], n_lat[3], n_sts[3], n_byte[3], n_rdy[3], n_rd[3];
  int s_mode[3], s_lat[3], s_sts[3], s_byte[3], s_rdy[3], s_rd[3];
  logic [1:0] l_fmt; logic [2:0] l_mode; logic l_bcd, l_msb; logic [7:0] l_data;

  always #10 clk = ~clk;

  pit_host_front u0 (.*);

  initial for (int i = 0; i < 3; i++) begin
    n_mode[i] = 0; n_lat[i] = 0; n_sts[i] = 0; n_byte[i] = 0; n_rdy[i] = 0; n_rd[i] = 0;
  end

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < 3; i++) begin
      if (ch_mode_we[i]) begin n_mode[i]++; l_fmt = cfg_fmt; l_mode = cfg_mode; l_bcd = cfg_bcd; end
      if (ch_cnt_latch[i]) n_lat[i]++;
      if (ch_sts_latch[i]) n_sts[i]++;
      if (ch_byte_we[i]) begin n_byte[i]++; l_data = byte_data; l_msb = byte_is_msb; end
      if (ch_count_ready[i]) n_rdy[i]++;
      if (ch_rd_done[i]) n_rd[i]++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic snap();
    for (int i = 0; i < 3; i++) begin
      s_mode[i] = n_mode[i]; s_lat[i] = n_lat[i]; s_sts[i] = n_sts[i];
      s_byte[i] = n_byte[i]; s_rdy[i] = n_rdy[i]; s_rd[i] = n_rd[i];
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
    @(negedge clk); cs_n = sel_n; addr = a; wdata = d;
    @(negedge clk); wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  // check deltas of mode/byte/ready for channel c
  task automatic exp_byte(input string req, input int c, input int nb, input int nr, input int msb, input int d);
    chk({req, " byte count"}, n_byte[c] - s_byte[c], nb);
    chk({req, " ready count"}, n_rdy[c] - s_rdy[c], nr);
    if (nb > 0) begin
      chk({req, " msb flag"}, l_msb, msb);
      chk({req, " data"}, l_data, d);
    end
  endtask

  task automatic t_reset_unprogrammed();
    chk("R11 mode_we idle", ch_mode_we, 0);
    chk("R11 byte_we idle", ch_byte_we, 0);
    chk("R11 latches idle", {ch_cnt_latch, ch_sts_latch}, 0);
    snap(); bus_wr(2'd0, 8'h11);
    exp_byte("R5 unprogrammed ch0", 0, 0, 0, 0, 0);
    snap(); bus_wr(2'd2, 8'h22);
    exp_byte("R5 unprogrammed ch2", 2, 0, 0, 0, 0);
  endtask

  task automatic t_cs_high();
    snap(); bus_wr(2'd3, 8'h14, 1'b1);
    chk("R1 cs high no mode_we", n_mode[0] - s_mode[0], 0);
    snap(); bus_wr(2'd0, 8'h99, 1'b1);
    chk("R1 cs high no byte", n_byte[0] - s_byte[0], 0);
  endtask

  task automatic t_single_formats();
    snap(); bus_wr(2'd3, 8'h14); // ch0 fmt 01 mode 2 binary
    chk("R2 ch0 mode_we", n_mode[0] - s_mode[0], 1);
    chk("R2 other mode_we", (n_mode[1] - s_mode[1]) + (n_mode[2] - s_mode[2]), 0);
    chk("R2 cfg fields", {l_fmt, l_mode, l_bcd}, {2'b01, 3'd2, 1'b0});
    snap(); bus_wr(2'd0, 8'h55);
    exp_byte("R6 lsb-only", 0, 1, 1, 0, 8'h55);
    snap(); bus_wr(2'd3, 8'h67); // ch1 fmt 10 mode 3 bcd
    chk("R2 ch1 cfg", {l_fmt, l_mode, l_bcd}, {2'b10, 3'd3, 1'b1});
    snap(); bus_wr(2'd1, 8'h12);
    exp_byte("R6 msb-only", 1, 1, 1, 1, 8'h12);
  endtask

  task automatic t_pair_interleave();
    snap(); bus_wr(2'd3, 8'hB0); // ch2 fmt 11 mode 0
    chk("R2 ch2 mode_we", n_mode[2] - s_mode[2], 1);
    snap(); bus_wr(2'd2, 8'h34);
    exp_byte("R7 first low", 2, 1, 0, 0, 8'h34);
    snap(); bus_wr(2'd3, 8'h30); // ch0 reprogrammed to pair, between ch2 bytes
    bus_wr(2'd2, 8'h12);
    exp_byte("R8 ch2 second high", 2, 1, 1, 1, 8'h12);
    snap(); bus_wr(2'd0, 8'h78);
    exp_byte("R8 ch0 restarted low", 0, 1, 0, 0, 8'h78);
    snap(); bus_wr(2'd2, 8'hAA);
    bus_wr(2'd3, 8'hB0);
    snap(); bus_wr(2'd2, 8'hBB);
    exp_byte("R7 restart after new cw", 2, 1, 0, 0, 8'hBB);
  endtask

  task automatic t_latch_cmd();
    snap(); bus_wr(2'd3, 8'h40); // ch1 latch command
    chk("R3 ch1 latch", n_lat[1] - s_lat[1], 1);
    chk("R3 no mode_we", n_mode[1] - s_mode[1], 0);
    chk("R3 others untouched", (n_lat[0] - s_lat[0]) + (n_lat[2] - s_lat[2]), 0);
    snap(); bus_wr(2'd1, 8'h9C);
    exp_byte("R3 format kept", 1, 1, 1, 1, 8'h9C);
  endtask

  task automatic t_readback();
    snap(); bus_wr(2'd3, 8'hDA); // count only, mask ch2+ch0
    chk("R4 count ch0", n_lat[0] - s_lat[0], 1);
    chk("R4 count ch1", n_lat[1] - s_lat[1], 0);
    chk("R4 count ch2", n_lat[2] - s_lat[2], 1);
    chk("R4 no status", (n_sts[0] - s_sts[0]) + (n_sts[1] - s_sts[1]) + (n_sts[2] - s_sts[2]), 0);
    chk("R4 no mode_we", (n_mode[0] - s_mode[0]) + (n_mode[2] - s_mode[2]), 0);
    snap(); bus_wr(2'd3, 8'hE4); // status only, ch1
    chk("R4 status ch1", n_sts[1] - s_sts[1], 1);
    chk("R4 status no count", n_lat[1] - s_lat[1], 0);
    snap(); bus_wr(2'd3, 8'hC2); // both, ch0
    chk("R4 both ch0", {n_lat[0] - s_lat[0], n_sts[0] - s_sts[0]}, {32'd1, 32'd1});
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp_d, input logic exp_oe, input string req);
    @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
    #2;
    chk({req, " rdata"}, bus_rdata, exp_d);
    chk({req, " oe"}, bus_oe, exp_oe);
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic t_read();
    #2;
    chk("R9 idle rdata", bus_rdata, 0);
    snap(); bus_rd(2'd1, 8'hB1, 1'b1, "R9 ch1");
    chk("R10 ch1 rd_done", n_rd[1] - s_rd[1], 1);
    snap(); bus_rd(2'd2, 8'hC2, 1'b1, "R9 ch2");
    chk("R10 ch2 rd_done", n_rd[2] - s_rd[2], 1);
    snap(); bus_rd(2'd3, 8'h00, 1'b0, "R9 ctrl port");
    chk("R10 ctrl no rd_done", (n_rd[0] - s_rd[0]) + (n_rd[1] - s_rd[1]) + (n_rd[2] - s_rd[2]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    t_reset_unprogrammed();
    t_cs_high();
    t_single_formats();
    t_pair_interleave();
    t_latch_cmd();
    t_readback();
    t_read();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule